// File: doc/BRIEF.md
# Dual-Edge Divide-by-Three Clock Generator

This block derives a clock at one third of the input frequency with a 50% duty cycle, starting from an input clock that is itself 50% duty. Two identical three-state phase counters run side by side. One advances on the rising input edge and the other on the falling input edge. The output clock is the OR of bit 0 of the two counters. When the falling-edge counter trails the rising-edge counter by exactly half an input period, each counter's bit 0 is high for one input period and the two windows overlap by half a period. The union is then 1.5 input periods high in every 3.

The half-period offset depends on which input edge arrives first after reset is released, so the block checks the offset at run time. Whenever the rising counter leaves its start state, the block samples bit 0 of the falling counter. If that bit is 0, the falling counter skips one advance and the check repeats one output period later. The first sample that reads 1 sets a sticky lock flag. The output clock is ungated cleanly two rising edges later, and it stays low until then. A small count output reports the phase of the rising counter.

Top module: `div3_dual_edge`

## Requirements
- R1: While `rst_in` is high, asynchronously and whatever the clock does, `clk_div_o` is 0, `locked_o` is 0 and `phase_cnt_o` is 0.
- R2: Each counter is a 2-bit state that starts at 01 and steps 01, 10, 00, 01 on its own edge. `phase_cnt_o` reports the rising counter's state, zero-extended to `CNT_W` bits: 0 for state 01, 1 for state 10, 2 for state 00. After release with the first edge rising, it reads 1, 2, 0 after the first, second and third rising edges.
- R3: Neither counter ever holds state 11, so `phase_cnt_o` never reads 3.
- R4: At every rising edge where the rising counter is in state 01, bit 0 of the falling counter is sampled. If it is 0 and the block is unlocked, the falling counter holds on the next falling edge. If it is 1, the block locks. When reset is released with the clock low, `locked_o` rises at the first rising edge. When it is released with the clock high, `locked_o` rises at the fourth rising edge.
- R5: Once set, `locked_o` stays 1 until reset.
- R6: `clk_div_o` stays 0 until the second rising edge after the edge that sets the lock, and first rises on that edge.
- R7: From then on, `clk_div_o` rises on every third rising edge and falls on the falling edge 1.5 input periods after each rise.
- R8: Asserting `rst_in` while `clk_div_o` is high drives `clk_div_o` and `locked_o` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, 50% duty |
| rst_in | input | 1 | Asynchronous active-high reset |
| clk_div_o | output | 1 | Divide-by-three clock, 50% duty once open |
| phase_cnt_o | output | CNT_W | Rising counter phase: 0, 1 or 2 |
| locked_o | output | 1 | Counters aligned; sticky until reset |

## Verification
A rising counter in a wrong or illegal state appears on `phase_cnt_o` half a period after the edge that produced it, as a skipped, repeated or out-of-range value. A falling counter that is still misaligned when the output opens cannot be seen on the count. It shows on the output clock within one output period, as a high time of one or two input periods instead of 1.5, or as an edge on the wrong input edge. A slip that is applied wrongly moves the lock edge away from the first or fourth rising edge. The bench therefore compares every output edge time with a queued expectation and samples lock and count between edges.

// File: rtl/div3_pkg.sv
package div3_pkg;
   localparam int PH_W = 2;
   typedef logic [PH_W-1:0] phase_t;

   localparam phase_t PH_START = 2'b01;
   localparam phase_t PH_MID   = 2'b10;
   localparam phase_t PH_LAST  = 2'b00;

   // three-state ring: 01 -> 10 -> 00 -> 01
   function automatic phase_t phase_step(input phase_t q);
      return {q[0], ~(q[0] | q[1])};
   endfunction

   function automatic logic [1:0] phase_index(input phase_t q);
      case (q)
         PH_MID:  return 2'd1;
         PH_LAST: return 2'd2;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/div3_phase_ctr.sv
module div3_phase_ctr
   import div3_pkg::*;
#(
   parameter bit NEG_EDGE = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   hold,
   output phase_t q
);
   generate
      if (NEG_EDGE) begin : g_fall
         always_ff @(negedge clk or posedge rst) begin
            if (rst)        q <= PH_START;
            else if (!hold) q <= phase_step(q);
         end
      end else begin : g_rise
         always_ff @(posedge clk or posedge rst) begin
            if (rst)        q <= PH_START;
            else if (!hold) q <= phase_step(q);
         end
      end
   endgenerate
endmodule

// File: rtl/div3_align.sv
module div3_align
   import div3_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  phase_t rise_q,
   input  logic   fall_b0,
   output logic   slip_o,
   output logic   locked_o,
   output logic   gate_o
);
   logic check_now;

   // the rising counter's bit 0 falls at this edge; sample the partner bit
   assign check_now = (rise_q == PH_START);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         slip_o   <= 1'b0;
         locked_o <= 1'b0;
         gate_o   <= 1'b0;
      end else begin
         slip_o <= check_now & ~fall_b0 & ~locked_o;
         if (check_now & fall_b0)
            locked_o <= 1'b1;
         // open only on entry to the all-low phase so the first pulse is whole
         if (locked_o && rise_q == PH_MID)
            gate_o <= 1'b1;
      end
   end
endmodule

// File: rtl/div3_out_stage.sv
module div3_out_stage
   import div3_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             gate,
   input  phase_t           rise_q,
   input  logic             fall_b0,
   output logic             clk_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [1:0] idx;

   assign idx   = phase_index(rise_q);
   assign cnt_o = CNT_W'(idx);
   assign clk_o = gate & (rise_q[0] | fall_b0);
endmodule

// File: rtl/div3_dual_edge.sv
module div3_dual_edge
   import div3_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk_in,
   input  logic             rst_in,
   output logic             clk_div_o,
   output logic [CNT_W-1:0] phase_cnt_o,
   output logic             locked_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   phase_t rise_q;
   phase_t fall_q;
   logic   slip;
   logic   gate;

   div3_phase_ctr #(.NEG_EDGE(1'b0)) u_rise (
      .clk (clk_in),
      .rst (rst_in),
      .hold(1'b0),
      .q   (rise_q)
   );

   div3_phase_ctr #(.NEG_EDGE(1'b1)) u_fall (
      .clk (clk_in),
      .rst (rst_in),
      .hold(slip),
      .q   (fall_q)
   );

   div3_align u_align (
      .clk     (clk_in),
      .rst     (rst_in),
      .rise_q  (rise_q),
      .fall_b0 (fall_q[0]),
      .slip_o  (slip),
      .locked_o(locked_o),
      .gate_o  (gate)
   );

   div3_out_stage #(.CNT_W(CNT_W)) u_out (
      .gate   (gate),
      .rise_q (rise_q),
      .fall_b0(fall_q[0]),
      .clk_o  (clk_div_o),
      .cnt_o  (phase_cnt_o)
   );
endmodule

// File: rtl/div3_dual_edge_chk.sv
module div3_dual_edge_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] rise_q,
   input logic [1:0] fall_q,
   input logic       slip,
   input logic       locked,
   input logic       clk_div
);
   a_r3_rise_legal: assert property (@(posedge clk) disable iff (rst)
      rise_q != 2'b11);

   a_r3_fall_legal: assert property (@(negedge clk) disable iff (rst)
      fall_q != 2'b11);

   a_r2_start_to_mid: assert property (@(posedge clk) disable iff (rst)
      rise_q == 2'b01 |=> rise_q == 2'b10);

   a_r2_mid_to_last: assert property (@(posedge clk) disable iff (rst)
      rise_q == 2'b10 |=> rise_q == 2'b00);

   a_r4_slip_holds: assert property (@(negedge clk) disable iff (rst)
      slip |=> $stable(fall_q));

   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      locked |=> locked);

   a_r6_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
      !locked |-> !clk_div);
endmodule

bind div3_dual_edge div3_dual_edge_chk u_chk (
   .clk    (clk_in),
   .rst    (rst_in),
   .rise_q (rise_q),
   .fall_q (fall_q),
   .slip   (slip),
   .locked (locked_o),
   .clk_div(clk_div_o)
);

// File: tb/div3_dual_edge_tb_top.sv
`timescale 1ns/1ps
module div3_dual_edge_tb_top;
   localparam int CNT_W = 2;
   localparam int TPER  = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             clk_div;
   logic [CNT_W-1:0] cnt;
   logic             locked;

   always #(TPER/2) clk = ~clk;

   div3_dual_edge #(.CNT_W(CNT_W)) dut_i (
      .clk_in     (clk),
      .rst_in     (rst),
      .clk_div_o  (clk_div),
      .phase_cnt_o(cnt),
      .locked_o   (locked)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      longint t;
      logic   v;
      string  req;
   } ev_t;

   ev_t expq[$];
   bit  mon_en = 1'b0;

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_until(input longint t);
      if ($time < t) #(t - $time);
   endtask

   // driver side of the scoreboard: queue the expected output edges
   task automatic push_train(input longint first_rise, input int n);
      for (int k = 0; k < n; k++) begin
         ev_t e;
         e.t = first_rise + 3*TPER*k;  e.v = 1'b1;
         e.req = (k == 0) ? "R6" : "R7";
         expq.push_back(e);
         e.t = first_rise + 3*TPER*k + 6; e.v = 1'b0; e.req = "R7";
         expq.push_back(e);
      end
   endtask

   // monitor side: every output edge must match the head of the queue
   always @(clk_div) begin
      if (mon_en) begin
         if (expq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6 unexpected edge at t=%0d: actual=%b expected=no edge",
                     $time, clk_div);
         end else begin
            ev_t e;
            e = expq.pop_front();
            chk(e.req, "edge time", $time, e.t);
            chk(e.req, "edge level", longint'(clk_div), longint'(e.v));
         end
      end
   end

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL R7 watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      longint n0;
      longint p0;
      longint t;

      // ---------- scenario A: release with clock low (first edge rising)
      repeat (2) @(posedge clk);
      @(negedge clk);
      n0 = $time;
      #1;
      chk("R1", "clk_div in reset", longint'(clk_div), 0);
      chk("R1", "locked in reset", longint'(locked), 0);
      chk("R1", "count in reset", longint'(cnt), 0);
      rst = 1'b0;
      expq.delete();
      push_train(n0 + 10, 6);
      mon_en = 1'b1;

      wait_until(n0 + 3);
      chk("R4", "lock after first rising edge", longint'(locked), 1);
      chk("R2", "count after edge 1", longint'(cnt), 1);
      wait_until(n0 + 7);
      chk("R2", "count after edge 2", longint'(cnt), 2);
      wait_until(n0 + 11);
      chk("R2", "count after edge 3", longint'(cnt), 0);

      for (int k = 0; k < 6; k++) begin
         t = n0 + 13 + 3*TPER*k;
         wait_until(t);
         chk("R5", "lock persists", longint'(locked), 1);
         chk("R3", "count not 3", longint'(cnt == 2'd3), 0);
      end

      wait_until(n0 + 78);
      mon_en = 1'b0;
      chk("R7", "all queued edges seen", longint'(expq.size()), 0);

      // next pulse is high from n0+82 to n0+88
      wait_until(n0 + 83);
      chk("R7", "output high before reset", longint'(clk_div), 1);
      rst = 1'b1;
      #1;
      chk("R8", "clk_div cleared by reset", longint'(clk_div), 0);
      chk("R8", "locked cleared by reset", longint'(locked), 0);
      chk("R1", "count cleared by reset", longint'(cnt), 0);

      // ---------- scenario B: release with clock high (first edge falling)
      repeat (3) @(posedge clk);
      p0 = $time;
      #1;
      rst = 1'b0;
      expq.delete();
      push_train(p0 + 24, 6);
      mon_en = 1'b1;

      wait_until(p0 + 5);
      chk("R2", "count after edge 1 (B)", longint'(cnt), 1);
      wait_until(p0 + 15);
      chk("R4", "no lock before slip completes", longint'(locked), 0);
      chk("R6", "output low while unlocked", longint'(clk_div), 0);
      wait_until(p0 + 17);
      chk("R4", "lock after fourth rising edge", longint'(locked), 1);
      wait_until(p0 + 23);
      chk("R6", "output low before gate opens", longint'(clk_div), 0);

      for (int k = 0; k < 6; k++) begin
         t = p0 + 25 + 3*TPER*k;
         wait_until(t);
         chk("R5", "lock persists (B)", longint'(locked), 1);
         chk("R2", "count at pulse start", longint'(cnt), 0);
      end

      wait_until(p0 + 92);
      mon_en = 1'b0;
      chk("R7", "all queued edges seen (B)", longint'(expq.size()), 0);

      done = 1'b1;
      finish_run();
   end
endmodule